// File: doc/BRIEF.md
# UART with Hardware XON/XOFF Flow Control

This block is a full-duplex serial port with a fixed frame of eight data bits, one stop bit and no parity. A free-running divider makes a one-cycle enable at sixteen times the baud rate, and both the receiver and the transmitter time their bits from it. Received bytes go into a 16-entry queue. The consumer sees the oldest byte on `rdData` whenever `rxDataPresent` is high, and pulses `rdStrobe` once it has taken that byte. The producer pushes bytes with `wrStrobe` into a second 16-entry queue, which the transmitter drains one frame at a time.

Software flow control is handled entirely in hardware. A change in the receive queue's half-full flag is caught by comparing the flag with a registered copy of itself. A rising flag schedules an XOFF character (0x13) and a falling flag schedules an XON character (0x11). The scheduled character goes out at the next frame boundary, ahead of any user bytes still waiting. If the flag flips again before the character has been sent, only the character matching the newest state is transmitted.

Top module: `uart_xonxoff`

## Requirements
- R1: `txOut` idles high. Each transmitted frame is one low start bit, eight data bits with the LSB first, and one high stop bit. User bytes leave in the order they were written.
- R2: The baud enable is a one-cycle pulse once every `CLK_DIV` clocks (default 27). Every transmitted bit after the start bit lasts exactly 16 enable pulses, and the start bit lasts between 15 and 16 pulse periods.
- R3: The receiver accepts a start bit only if the line is still low at the 8th enable pulse after the falling edge. It then samples each data bit every 16 pulses, LSB first. Received bytes appear on `rdData` in arrival order, and the oldest byte is shown while `rxDataPresent` is high.
- R4: A received frame whose stop-bit sample is low is discarded. The receiver waits for the line to return high before it looks for the next start bit.
- R5: A low pulse shorter than half a bit time on `rxIn` does not produce a byte.
- R6: For each queue, the data-present flag is high when the queue holds at least 1 entry, the half-full flag when it holds at least 8, and the full flag when it holds 16. A `rdStrobe` pulse removes the head byte.
- R7: A write while the transmit queue is full, and a byte that arrives while the receive queue is full, are both discarded. The entries already stored are not changed.
- R8: When the receive half-full flag goes from low to high, the byte 0x13 is transmitted. When it goes from high to low, the byte 0x11 is transmitted.
- R9: A scheduled flow-control byte is sent at the next frame boundary, before any queued user byte.
- R10: If the half-full flag changes again before the scheduled flow-control byte has started, only the byte that matches the latest flag state is sent.
- R11: While `rst` is high and right after it is released, `txOut` is high and all six status flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rxIn | input | 1 | Serial receive line |
| txOut | output | 1 | Serial transmit line |
| wrData | input | 8 | Byte to transmit |
| wrStrobe | input | 1 | Pushes `wrData` into the transmit queue |
| txDataPresent | output | 1 | Transmit queue holds at least one byte |
| txFull | output | 1 | Transmit queue holds 16 bytes |
| txHalfFull | output | 1 | Transmit queue holds at least 8 bytes |
| rdData | output | 8 | Oldest received byte |
| rdStrobe | input | 1 | Removes the oldest received byte |
| rxDataPresent | output | 1 | Receive queue holds at least one byte |
| rxFull | output | 1 | Receive queue holds 16 bytes |
| rxHalfFull | output | 1 | Receive queue holds at least 8 bytes |

## Verification
The two functions that can compete at the same moment are a scheduled flow-control byte and a queued user byte, both waiting for the transmitter to become free. The bench provokes this by queueing four user bytes and then completing the eighth received frame while the first user byte is still on the line. The scoreboard then expects the flow byte right after that first user byte. In a second run the bench pops a received byte immediately after half-full rises, within that same frame. The expected stream then holds XON in that slot and no XOFF at all. Order is judged by decoding every frame on `txOut` and comparing it with the expected queue.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;

  localparam logic [7:0] XON_CHAR  = 8'h11;
  localparam logic [7:0] XOFF_CHAR = 8'h13;

  // Strobes from the control module to the datapath, valid for one cycle
  typedef struct packed {
    logic       sendFlow;   // load flowByte into the serializer
    logic       sendUser;   // load the transmit queue head and pop it
    logic [7:0] flowByte;
  } fc_strobe_t;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_HOLD
  } rx_state_t;

endpackage

// File: rtl/uart_fc_fifo.sv
module uart_fc_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             present,
  output logic             full,
  output logic             half
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr;
  logic [AW-1:0]    rdPtr;
  logic [CW-1:0]    count;
  logic             doPush;
  logic             doPop;

  assign doPush  = push && (count != CW'(DEPTH));
  assign doPop   = pop && (count != '0);
  assign dout    = mem[rdPtr];
  assign present = (count != '0);
  assign full    = (count == CW'(DEPTH));
  assign half    = (count >= CW'(DEPTH / 2));

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + AW'(1);
      if (doPop)  rdPtr <= rdPtr + AW'(1);
      count <= count + CW'(doPush) - CW'(doPop);
    end
  end

  // A push into a full queue must leave it full with the same head entry
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> (full && $stable(dout)));

  // An accepted push always makes data visible on the next cycle
  assert_present_after_push_R6: assert property (@(posedge clk) disable iff (rst)
    (push && !full) |=> present);

endmodule

// File: rtl/uart_fc_datapath.sv
module uart_fc_datapath
  import uart_fc_pkg::*;
#(
  parameter int CLK_DIV    = 27,
  parameter int FIFO_DEPTH = 16,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxIn,
  output logic              txOut,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrStrobe,
  output logic              txDataPresent,
  output logic              txFull,
  output logic              txHalfFull,
  output logic [DATA_W-1:0] rdData,
  input  logic              rdStrobe,
  output logic              rxDataPresent,
  output logic              rxFull,
  output logic              rxHalfFull,
  input  fc_strobe_t        strb,
  output logic              txIdle
);

  localparam int BW       = $clog2(CLK_DIV);
  localparam int NQ       = 2;          // queue 0 receive, queue 1 transmit
  localparam int FRAME_B  = DATA_W + 2;
  localparam int LW       = $clog2(FRAME_B + 1);
  localparam int BIDX_W   = $clog2(DATA_W);

  // ---------------- baud enable ----------------
  logic [BW-1:0] baudCnt;
  logic          baudTick;

  always_ff @(posedge clk) begin
    if (rst) begin
      baudCnt  <= '0;
      baudTick <= 1'b0;
    end else if (baudCnt == BW'(CLK_DIV - 1)) begin
      baudCnt  <= '0;
      baudTick <= 1'b1;
    end else begin
      baudCnt  <= baudCnt + BW'(1);
      baudTick <= 1'b0;
    end
  end

  assert_tick_single_R2: assert property (@(posedge clk) disable iff (rst)
    baudTick |=> !baudTick);

  // ---------------- queues ----------------
  logic [NQ-1:0]             fPush;
  logic [NQ-1:0]             fPop;
  logic [NQ-1:0][DATA_W-1:0] fDin;
  logic [NQ-1:0][DATA_W-1:0] fDout;
  logic [NQ-1:0]             fPres;
  logic [NQ-1:0]             fFull;
  logic [NQ-1:0]             fHalf;

  for (genvar g = 0; g < NQ; g++) begin : g_queue
    uart_fc_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk    (clk),
      .rst    (rst),
      .push   (fPush[g]),
      .pop    (fPop[g]),
      .din    (fDin[g]),
      .dout   (fDout[g]),
      .present(fPres[g]),
      .full   (fFull[g]),
      .half   (fHalf[g])
    );
  end

  assign rdData        = fDout[0];
  assign rxDataPresent = fPres[0];
  assign rxFull        = fFull[0];
  assign rxHalfFull    = fHalf[0];
  assign txDataPresent = fPres[1];
  assign txFull        = fFull[1];
  assign txHalfFull    = fHalf[1];

  // ---------------- receiver ----------------
  logic [1:0]        rxSync;
  logic              rxLine;
  rx_state_t         rxState;
  logic [3:0]        rxTicks;
  logic [BIDX_W-1:0] rxBit;
  logic [DATA_W-1:0] rxShift;
  logic              rxPush;

  assign rxLine = rxSync[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      rxSync  <= 2'b11;
      rxState <= RX_IDLE;
      rxTicks <= '0;
      rxBit   <= '0;
      rxShift <= '0;
      rxPush  <= 1'b0;
    end else begin
      rxSync <= {rxSync[0], rxIn};
      rxPush <= 1'b0;
      unique case (rxState)
        RX_IDLE: begin
          if (baudTick && !rxLine) begin
            rxState <= RX_START;
            rxTicks <= '0;
          end
        end
        RX_START: begin
          if (baudTick) begin
            if (rxTicks == 4'd7) begin
              rxTicks <= '0;
              rxBit   <= '0;
              rxState <= rxLine ? RX_IDLE : RX_DATA;
            end else begin
              rxTicks <= rxTicks + 4'd1;
            end
          end
        end
        RX_DATA: begin
          if (baudTick) begin
            if (rxTicks == 4'd15) begin
              rxTicks <= '0;
              rxShift <= {rxLine, rxShift[DATA_W-1:1]};
              if (rxBit == BIDX_W'(DATA_W - 1)) rxState <= RX_STOP;
              else                               rxBit   <= rxBit + BIDX_W'(1);
            end else begin
              rxTicks <= rxTicks + 4'd1;
            end
          end
        end
        RX_STOP: begin
          if (baudTick) begin
            if (rxTicks == 4'd15) begin
              rxTicks <= '0;
              if (rxLine) begin
                rxPush  <= 1'b1;
                rxState <= RX_IDLE;
              end else begin
                rxState <= RX_HOLD;
              end
            end else begin
              rxTicks <= rxTicks + 4'd1;
            end
          end
        end
        RX_HOLD: begin
          if (rxLine) rxState <= RX_IDLE;
        end
        default: rxState <= RX_IDLE;
      endcase
    end
  end

  assign fPush[0] = rxPush;
  assign fPop[0]  = rdStrobe;
  assign fDin[0]  = rxShift;

  // A byte is only stored while the stop bit is still high on the line
  assert_stop_high_R4: assert property (@(posedge clk) disable iff (rst)
    rxPush |-> rxLine);

  // ---------------- transmitter ----------------
  logic               txBusy;
  logic [FRAME_B-1:0] txShift;
  logic [3:0]         txTicks;
  logic [LW-1:0]      txLeft;
  logic               txLoad;
  logic [DATA_W-1:0]  txByte;

  assign txIdle   = !txBusy;
  assign txLoad   = !txBusy && (strb.sendFlow || strb.sendUser);
  assign txByte   = strb.sendFlow ? strb.flowByte : fDout[1];
  assign fPush[1] = wrStrobe;
  assign fPop[1]  = !txBusy && strb.sendUser;
  assign fDin[1]  = wrData;
  assign txOut    = txShift[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      txBusy  <= 1'b0;
      txShift <= '1;
      txTicks <= '0;
      txLeft  <= '0;
    end else if (txLoad) begin
      txBusy  <= 1'b1;
      txShift <= {1'b1, txByte, 1'b0};
      txTicks <= '0;
      txLeft  <= LW'(FRAME_B);
    end else if (txBusy && baudTick) begin
      if (txTicks == 4'd15) begin
        txTicks <= '0;
        txShift <= {1'b1, txShift[FRAME_B-1:1]};
        txLeft  <= txLeft - LW'(1);
        if (txLeft == LW'(1)) txBusy <= 1'b0;
      end else begin
        txTicks <= txTicks + 4'd1;
      end
    end
  end

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
    !txBusy |-> txOut);

  assert_single_load_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.sendFlow, strb.sendUser}));

endmodule

// File: rtl/uart_fc_ctrl.sv
module uart_fc_ctrl
  import uart_fc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rxHalf,
  input  logic       txHasData,
  input  logic       txIdle,
  output fc_strobe_t strb
);

  logic       hfPrev;
  logic       hfEvent;
  logic       pendValid;
  logic [7:0] pendByte;

  assign hfEvent = hfPrev ^ rxHalf;

  always_ff @(posedge clk) begin
    if (rst) begin
      hfPrev    <= 1'b0;
      pendValid <= 1'b0;
      pendByte  <= XON_CHAR;
    end else begin
      hfPrev <= rxHalf;
      if (hfEvent) begin
        pendValid <= 1'b1;
        pendByte  <= rxHalf ? XOFF_CHAR : XON_CHAR;
      end else if (strb.sendFlow) begin
        pendValid <= 1'b0;
      end
    end
  end

  // Nothing starts in an event cycle, so the newest flow byte always wins
  always_comb begin
    strb.flowByte = pendByte;
    strb.sendFlow = txIdle && pendValid && !hfEvent;
    strb.sendUser = txIdle && !pendValid && !hfEvent && txHasData;
  end

  assert_xoff_on_rise_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(rxHalf) |=> (pendValid && pendByte == XOFF_CHAR));

  assert_xon_on_fall_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(rxHalf) |=> (pendValid && pendByte == XON_CHAR));

  // A changed flag replaces any flow byte that has not started yet
  assert_latest_only_R10: assert property (@(posedge clk) disable iff (rst)
    (pendValid && hfEvent) |=> (pendByte == (rxHalf ? XOFF_CHAR : XON_CHAR)));

endmodule

// File: rtl/uart_xonxoff.sv
module uart_xonxoff
  import uart_fc_pkg::*;
#(
  parameter int CLK_DIV    = 27,
  parameter int FIFO_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rxIn,
  output logic       txOut,
  input  logic [7:0] wrData,
  input  logic       wrStrobe,
  output logic       txDataPresent,
  output logic       txFull,
  output logic       txHalfFull,
  output logic [7:0] rdData,
  input  logic       rdStrobe,
  output logic       rxDataPresent,
  output logic       rxFull,
  output logic       rxHalfFull
);

  fc_strobe_t strb;
  logic       txIdle;

  uart_fc_datapath #(.CLK_DIV(CLK_DIV), .FIFO_DEPTH(FIFO_DEPTH), .DATA_W(8)) u_dp (
    .clk          (clk),
    .rst          (rst),
    .rxIn         (rxIn),
    .txOut        (txOut),
    .wrData       (wrData),
    .wrStrobe     (wrStrobe),
    .txDataPresent(txDataPresent),
    .txFull       (txFull),
    .txHalfFull   (txHalfFull),
    .rdData       (rdData),
    .rdStrobe     (rdStrobe),
    .rxDataPresent(rxDataPresent),
    .rxFull       (rxFull),
    .rxHalfFull   (rxHalfFull),
    .strb         (strb),
    .txIdle       (txIdle)
  );

  uart_fc_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .rxHalf   (rxHalfFull),
    .txHasData(txDataPresent),
    .txIdle   (txIdle),
    .strb     (strb)
  );

endmodule

// File: tb/test_uart_xonxoff.sv
module test_uart_xonxoff;

  localparam int DIV   = 8;
  localparam int BIT   = 16 * DIV;
  localparam int DEPTH = 16;
  localparam logic [7:0] XON  = 8'h11;
  localparam logic [7:0] XOFF = 8'h13;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxIn = 1'b1;
  logic       txOut;
  logic [7:0] wrData = 8'h00;
  logic       wrStrobe = 1'b0;
  logic       txDataPresent, txFull, txHalfFull;
  logic [7:0] rdData;
  logic       rdStrobe = 1'b0;
  logic       rxDataPresent, rxFull, rxHalfFull;

  int nChecks = 0;
  int nFails  = 0;
  logic [7:0] txExp[$];
  logic [7:0] rxModel[$];

  always #10 clk = ~clk;

  uart_xonxoff #(.CLK_DIV(DIV), .FIFO_DEPTH(DEPTH)) i_uart_xonxoff (
    .clk(clk), .rst(rst), .rxIn(rxIn), .txOut(txOut),
    .wrData(wrData), .wrStrobe(wrStrobe),
    .txDataPresent(txDataPresent), .txFull(txFull), .txHalfFull(txHalfFull),
    .rdData(rdData), .rdStrobe(rdStrobe),
    .rxDataPresent(rxDataPresent), .rxFull(rxFull), .rxHalfFull(rxHalfFull)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic writeTx(input logic [7:0] b);
    @(negedge clk); wrData = b; wrStrobe = 1'b1;
    @(negedge clk); wrStrobe = 1'b0;
  endtask

  task automatic expectTx(input logic [7:0] b);
    txExp.push_back(b);
  endtask

  task automatic rxSend(input logic [7:0] b, input logic stopBit);
    @(negedge clk); rxIn = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxIn = b[i];
      repeat (BIT) @(negedge clk);
    end
    rxIn = stopBit;
    if (stopBit && rxModel.size() < DEPTH) rxModel.push_back(b);
    repeat (BIT) @(negedge clk);
    rxIn = 1'b1;
  endtask

  task automatic popRx(input string req);
    logic [7:0] e;
    @(negedge clk);
    e = rxModel.pop_front();
    chk(rxDataPresent && rdData == e, req, int'(rdData), int'(e));
    rdStrobe = 1'b1;
    @(negedge clk); rdStrobe = 1'b0;
  endtask

  task automatic waitTxDone();
    while (txExp.size() != 0) @(negedge clk);
    repeat (BIT) @(negedge clk);
  endtask

  // Monitor: decode frames on txOut and pop the scoreboard
  initial begin
    logic [7:0] b;
    forever begin
      @(negedge clk);
      if (!rst && !txOut) begin
        repeat (8 * DIV) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          repeat (BIT) @(negedge clk);
          b[i] = txOut;
        end
        repeat (BIT) @(negedge clk);
        chk(txOut == 1'b1, "R1 stop bit", int'(txOut), 1);
        if (txExp.size() == 0) begin
          chk(1'b0, "R1 R7 unexpected tx byte", int'(b), 0);
        end else begin
          logic [7:0] e;
          e = txExp.pop_front();
          chk(b == e, "R1 R8 R9 R10 tx byte order", int'(b), int'(e));
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (190000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    int lowLen;
    repeat (5) @(negedge clk);
    // R11 reset state
    chk(txOut == 1'b1, "R11 txOut in reset", int'(txOut), 1);
    chk({txDataPresent, txFull, txHalfFull, rxDataPresent, rxFull, rxHalfFull} == 6'b0,
        "R11 flags in reset", 0, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(txOut == 1'b1, "R11 txOut after reset", int'(txOut), 1);

    // R1 R2: three frames, measure the low run of 0x00
    expectTx(8'h00); expectTx(8'hA5); expectTx(8'h3C);
    writeTx(8'h00); writeTx(8'hA5); writeTx(8'h3C);
    chk(txDataPresent == 1'b1, "R6 tx data present", int'(txDataPresent), 1);
    while (txOut) @(negedge clk);
    lowLen = 0;
    while (!txOut) begin @(negedge clk); lowLen++; end
    chk(lowLen >= 143 * DIV - 1 && lowLen <= 144 * DIV + 1, "R2 nine low bits", lowLen, 144 * DIV);
    waitTxDone();
    chk(txDataPresent == 1'b0, "R6 tx queue empty", int'(txDataPresent), 0);

    // R3 receive order
    rxSend(8'h5A, 1'b1);
    rxSend(8'hC3, 1'b1);
    repeat (BIT) @(negedge clk);
    popRx("R3 first byte");
    popRx("R3 second byte");
    @(negedge clk);
    chk(rxDataPresent == 1'b0, "R6 rx empty after pops", int'(rxDataPresent), 0);

    // R4 bad stop bit dropped, then recovery
    rxSend(8'h77, 1'b0);
    repeat (3 * BIT) @(negedge clk);
    chk(rxDataPresent == 1'b0, "R4 bad frame dropped", int'(rxDataPresent), 0);
    rxSend(8'h81, 1'b1);
    repeat (BIT) @(negedge clk);
    popRx("R4 recovery byte");

    // R5 short glitch
    @(negedge clk); rxIn = 1'b0;
    repeat (3 * DIV) @(negedge clk);
    rxIn = 1'b1;
    repeat (12 * BIT) @(negedge clk);
    chk(rxDataPresent == 1'b0, "R5 glitch ignored", int'(rxDataPresent), 0);

    // R6 R8 threshold crossing, transmitter idle
    for (int i = 0; i < 7; i++) rxSend(8'(8'h20 + i), 1'b1);
    repeat (BIT) @(negedge clk);
    chk(rxHalfFull == 1'b0 && rxDataPresent == 1'b1, "R6 seven entries", int'(rxHalfFull), 0);
    expectTx(XOFF);
    rxSend(8'h27, 1'b1);
    repeat (BIT) @(negedge clk);
    chk(rxHalfFull == 1'b1 && rxFull == 1'b0, "R6 eight entries half", int'(rxHalfFull), 1);
    waitTxDone();
    expectTx(XON);
    popRx("R8 pop below half");
    waitTxDone();
    chk(rxHalfFull == 1'b0, "R8 half cleared", int'(rxHalfFull), 0);

    // R9 flow byte jumps ahead of queued user bytes
    expectTx(8'hA0); expectTx(XOFF); expectTx(8'hA1); expectTx(8'hA2); expectTx(8'hA3);
    writeTx(8'hA0); writeTx(8'hA1); writeTx(8'hA2); writeTx(8'hA3);
    rxSend(8'h30, 1'b1);
    waitTxDone();
    expectTx(XON);
    popRx("R9 pop after");
    waitTxDone();

    // R10 flag toggles back before the flow byte starts
    expectTx(8'hB0); expectTx(XON); expectTx(8'hB1); expectTx(8'hB2); expectTx(8'hB3);
    writeTx(8'hB0); writeTx(8'hB1); writeTx(8'hB2); writeTx(8'hB3);
    fork
      rxSend(8'h31, 1'b1);
      begin
        while (!rxHalfFull) @(negedge clk);
        popRx("R10 quick pop");
      end
    join
    waitTxDone();
    chk(rxHalfFull == 1'b0, "R10 half low after toggle", int'(rxHalfFull), 0);

    // R7 receive queue full
    expectTx(XOFF);
    for (int i = 0; i < 9; i++) rxSend(8'(8'h60 + i), 1'b1);
    repeat (BIT) @(negedge clk);
    chk(rxFull == 1'b1, "R6 rx full at sixteen", int'(rxFull), 1);
    rxSend(8'hEE, 1'b1);
    repeat (BIT) @(negedge clk);
    chk(rxFull == 1'b1, "R7 rx still full", int'(rxFull), 1);
    waitTxDone();

    // R7 transmit queue full: 17 accepted, 18th dropped
    for (int i = 0; i < 17; i++) expectTx(8'(8'h40 + i));
    for (int i = 0; i < 18; i++) writeTx(8'(8'h40 + i));
    @(negedge clk);
    chk(txFull == 1'b1 && txHalfFull == 1'b1, "R6 tx full", int'(txFull), 1);
    waitTxDone();
    repeat (3 * 10 * BIT) @(negedge clk);

    // Drain receive queue; dropped 0xEE must not appear
    expectTx(XON);
    for (int i = 0; i < DEPTH; i++) popRx("R7 rx contents");
    @(negedge clk);
    chk(rxDataPresent == 1'b0, "R7 dropped byte absent", int'(rxDataPresent), 0);
    waitTxDone();
    chk(txExp.size() == 0, "R1 all frames seen", txExp.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule